// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM refreshed and brings it out of power-up. After reset it holds the row strobe high for a programmable pause, then runs eight wake-up refresh cycles. Only after that does it raise `init_done`, which the access controller uses to admit normal traffic. From then on an interval timer marks one refresh as due every `INTERVAL_CLKS` clocks. Due refreshes that the controller cannot serve at once are held in a saturating backlog.

Each refresh, including the wake-up ones, is obtained through a request/grant handshake with the access controller. The sequencer raises `bus_req`. The controller answers with `bus_gnt` only while `bus_req` is high, and keeps it high until `bus_req` falls. Once granted, the sequencer drives RAS, CAS and WE itself and flags this on `seq_active`. It runs every pending refresh back to back before it drops `bus_req`.

The `mode_ras_only` input picks the refresh type, and it is sampled once at the start of each refresh. When it is 0, CAS falls before RAS, so the DRAM refreshes from its own row counter. When it is 1, CAS stays high and the block presents its own 10-bit row on `row_addr`. WE is kept high in every refresh, so a CAS-first cycle never becomes a test-mode entry.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low: `ras_n`, `cas_n` and `we_n` are 1; `bus_req`, `seq_active` and `init_done` are 0; `row_addr` is 0.
- R2: `ras_n` falls only while `bus_gnt` is 1. Inside one grant, consecutive refreshes start `T_SETUP+T_ACTIVE+T_PRECH` clocks apart, with no release of `bus_req` between them.
- R3: In CAS-first mode (`mode_ras_only`=0 when the cycle starts), `cas_n` is low for at least `T_SETUP` clocks before `ras_n` falls and stays low until `ras_n` rises.
- R4: `we_n` is 1 at every falling edge of `ras_n`.
- R5: In row mode (`mode_ras_only`=1), `cas_n` stays 1 for the whole cycle and `row_addr` is stable while `ras_n` is low. `row_addr` advances by one after each row-mode cycle, wrapping from 1023 to 0. CAS-first cycles leave it unchanged.
- R6: `bus_req` stays 0 for the first `PAUSE_CLKS` clock edges after reset is released.
- R7: Exactly `WAKE_CYCLES` (8) refreshes are issued with `init_done`=0. `init_done` rises at the end of the 8th and then stays 1.
- R8: Once `init_done` is 1 and no refreshes are queued, successive refreshes start exactly `INTERVAL_CLKS` clocks apart when the grant delay is constant.
- R9: Refreshes that fall due without a grant are counted up to `MAX_PEND` (8), and further ones are dropped. The whole backlog is issued back to back under one grant.
- R10: A change of `mode_ras_only` while a refresh is under way does not alter that refresh: the level of `cas_n` and the value of `row_addr` stay constant while `ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ras_only | input | 1 | 0: CAS-first refresh, 1: row-address refresh |
| bus_gnt | input | 1 | Grant from the access controller, held until `bus_req` falls |
| bus_req | output | 1 | Request for the DRAM strobes |
| seq_active | output | 1 | Sequencer is driving the strobes this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_BITS | Row for row-mode refresh |
| init_done | output | 1 | Wake-up finished, normal access allowed |

## Verification
Every refresh is classified at its RAS edge from the CAS level, and the class must hold until RAS rises. Classifying this way separates a correct setup order from a swapped one, and a latched mode from a live one.

The main function is driven in several ways:
- A constant zero grant delay isolates the interval timer. It turns an off-by-one in the period into a spacing error.
- A long grant denial fills the backlog past its limit. This exposes missing saturation and any release of the grant between queued cycles.
- Random grant delays and random mode toggles mix both refresh types.
- A long row-mode run crosses the 1023-to-0 wrap of the row counter.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {PH_PAUSE, PH_WAKE, PH_RUN} init_phase_t;
  typedef enum logic [2:0] {CY_IDLE, CY_REQ, CY_SETUP, CY_ACTIVE, CY_PRECH} cyc_state_t;
endpackage

// File: rtl/rfsh_init_ctrl.sv
module rfsh_init_ctrl
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CLKS  = 200,
  parameter int WAKE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_done,
  output logic pausing,
  output logic waking,
  output logic more_wake,
  output logic init_done
);
  localparam int PW = $clog2(PAUSE_CLKS + 1);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  init_phase_t   phase_q;
  logic [PW-1:0] pause_q;
  logic [WW-1:0] wake_left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_PAUSE;
      pause_q     <= '0;
      wake_left_q <= WW'(WAKE_CYCLES);
    end else begin
      case (phase_q)
        PH_PAUSE: begin
          if (pause_q == PW'(PAUSE_CLKS - 1)) phase_q <= PH_WAKE;
          else pause_q <= pause_q + 1'b1;
        end
        PH_WAKE: begin
          if (cyc_done) begin
            wake_left_q <= wake_left_q - 1'b1;
            if (wake_left_q == WW'(1)) phase_q <= PH_RUN;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign pausing   = (phase_q == PH_PAUSE);
  assign waking    = (phase_q == PH_WAKE);
  assign init_done = (phase_q == PH_RUN);
  assign more_wake = (wake_left_q > WW'(1));

  // R7: the ready flag may only rise on the cycle that closes a wake-up refresh
  assert_ready_after_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(cyc_done));
  // R6: no refresh may complete during the power-up pause
  assert_quiet_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pausing |-> !cyc_done);
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int INTERVAL_CLKS = 1560,
  parameter int MAX_PEND      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic cyc_done,
  output logic any_work,
  output logic more_work
);
  localparam int IW  = (INTERVAL_CLKS > 2) ? $clog2(INTERVAL_CLKS) : 1;
  localparam int PCW = $clog2(MAX_PEND + 1);

  logic [IW-1:0]  ivl_q;
  logic [PCW-1:0] pend_q;
  logic           tick;
  logic           inc;

  assign tick = run_en && (ivl_q == IW'(INTERVAL_CLKS - 1));
  assign inc  = tick && ((pend_q != PCW'(MAX_PEND)) || cyc_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      pend_q <= '0;
    end else begin
      if (run_en) ivl_q <= tick ? '0 : ivl_q + 1'b1;
      case ({inc, cyc_done})
        2'b10:   pend_q <= pend_q + 1'b1;
        2'b01:   if (pend_q != '0) pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign any_work  = (pend_q != '0);
  assign more_work = (pend_q > PCW'(1));

  // R9: the queue of due refreshes never passes its limit
  assert_backlog_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PCW'(MAX_PEND));
  // R9: a refresh in normal operation only completes when one was owed
  assert_done_has_work_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> pend_q != '0);
endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
  import rfsh_pkg::*;
#(
  parameter int T_SETUP  = 2,
  parameter int T_ACTIVE = 5,
  parameter int T_PRECH  = 4,
  parameter int ROW_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_ras_only,
  input  logic                bus_gnt,
  input  logic                any_work,
  input  logic                more_work,
  output logic                bus_req,
  output logic                seq_active,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                cyc_done
);
  localparam int TW = $clog2(T_SETUP + T_ACTIVE + T_PRECH + 1);

  cyc_state_t          st_q;
  logic [TW-1:0]       tcnt_q;
  logic                mode_q;
  logic [ROW_BITS-1:0] row_q;
  logic                last_setup, last_active, last_prech;

  assign last_setup  = (tcnt_q == TW'(T_SETUP - 1));
  assign last_active = (tcnt_q == TW'(T_ACTIVE - 1));
  assign last_prech  = (tcnt_q == TW'(T_PRECH - 1));
  assign cyc_done    = (st_q == CY_PRECH) && last_prech;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CY_IDLE;
      tcnt_q <= '0;
      mode_q <= 1'b0;
      row_q  <= '0;
    end else begin
      case (st_q)
        CY_IDLE: if (any_work) st_q <= CY_REQ;
        CY_REQ: begin
          if (bus_gnt) begin
            st_q   <= CY_SETUP;
            tcnt_q <= '0;
            mode_q <= mode_ras_only;
          end
        end
        CY_SETUP: begin
          if (last_setup) begin
            st_q   <= CY_ACTIVE;
            tcnt_q <= '0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        CY_ACTIVE: begin
          if (last_active) begin
            st_q   <= CY_PRECH;
            tcnt_q <= '0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        CY_PRECH: begin
          if (last_prech) begin
            tcnt_q <= '0;
            if (mode_q) row_q <= row_q + 1'b1;
            if (more_work && bus_gnt) begin
              st_q   <= CY_SETUP;
              mode_q <= mode_ras_only;
            end else st_q <= CY_IDLE;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        default: st_q <= CY_IDLE;
      endcase
    end
  end

  assign seq_active = (st_q == CY_SETUP) || (st_q == CY_ACTIVE) || (st_q == CY_PRECH);
  assign bus_req    = seq_active || (st_q == CY_REQ);
  assign ras_n      = (st_q != CY_ACTIVE);
  assign cas_n      = !(!mode_q && ((st_q == CY_SETUP) || (st_q == CY_ACTIVE)));
  assign we_n       = 1'b1;
  assign row_addr   = row_q;

  // R2: the row strobe only drops under a grant
  assert_strobe_under_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> bus_gnt);
  // R3: a CAS-first cycle has CAS already low before RAS falls
  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !mode_q) |-> ($past(cas_n) == 1'b0));
  // R5: the presented row holds while RAS is low
  assert_row_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n)) |-> $stable(row_addr));
  // R10: CAS level does not change inside an active refresh
  assert_kind_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n)) |-> $stable(cas_n));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CLKS    = 200,
  parameter int WAKE_CYCLES   = 8,
  parameter int INTERVAL_CLKS = 1560,
  parameter int MAX_PEND      = 8,
  parameter int ROW_BITS      = 10,
  parameter int T_SETUP       = 2,
  parameter int T_ACTIVE      = 5,
  parameter int T_PRECH       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_ras_only,
  input  logic                bus_gnt,
  output logic                bus_req,
  output logic                seq_active,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                init_done
);
  logic pausing, waking, more_wake;
  logic run_any, run_more;
  logic any_work, more_work;
  logic cyc_done;

  rfsh_init_ctrl #(
    .PAUSE_CLKS (PAUSE_CLKS),
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_init (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_done (cyc_done && waking),
    .pausing  (pausing),
    .waking   (waking),
    .more_wake(more_wake),
    .init_done(init_done)
  );

  rfsh_backlog #(
    .INTERVAL_CLKS(INTERVAL_CLKS),
    .MAX_PEND     (MAX_PEND)
  ) u_backlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (init_done),
    .cyc_done (cyc_done && init_done),
    .any_work (run_any),
    .more_work(run_more)
  );

  assign any_work  = waking ? 1'b1 : run_any;
  assign more_work = waking ? more_wake : run_more;

  rfsh_cycle_fsm #(
    .T_SETUP (T_SETUP),
    .T_ACTIVE(T_ACTIVE),
    .T_PRECH (T_PRECH),
    .ROW_BITS(ROW_BITS)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_ras_only(mode_ras_only),
    .bus_gnt      (bus_gnt),
    .any_work     (any_work),
    .more_work    (more_work),
    .bus_req      (bus_req),
    .seq_active   (seq_active),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .row_addr     (row_addr),
    .cyc_done     (cyc_done)
  );

  // R6: nothing is requested while the power-up pause runs
  assert_no_req_in_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pausing |-> !bus_req);
endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE      = 20;
  localparam int INTERVAL   = 128;
  localparam int TS = 1, TA = 3, TP = 2;
  localparam int CYC_LEN    = TS + TA + TP;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0, mode_ras_only = 1'b0, bus_gnt = 1'b0;
  logic bus_req, seq_active, ras_n, cas_n, we_n, init_done;
  logic [9:0] row_addr;

  int n_checks = 0, n_fail = 0;
  bit allow_gnt = 1'b1, random_gnt = 1'b0;
  int dly_cnt = 0;

  bit prev_ras = 1'b1, prev_req = 1'b0, cur_ro = 1'b0, kind_bad = 1'b0, wrap_seen = 1'b0;
  int cyc_no = 0, last_fall = 0, spacing = 0, cas_low_run = 0;
  int falls_total = 0, wake_falls = 0, ro_falls = 0, tenure_falls = 0, last_tenure = 0;
  logic [9:0] exp_row = '0, fall_row = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CLKS(PAUSE), .WAKE_CYCLES(8), .INTERVAL_CLKS(INTERVAL), .MAX_PEND(8),
    .ROW_BITS(10), .T_SETUP(TS), .T_ACTIVE(TA), .T_PRECH(TP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mode_ras_only(mode_ras_only), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .seq_active(seq_active), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .row_addr(row_addr), .init_done(init_done)
  );

  function automatic logic [9:0] next_row(input logic [9:0] r);
    return (r == 10'd1023) ? 10'd0 : r + 10'd1;
  endfunction

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_fall();
    int f = falls_total;
    while (falls_total == f) step();
  endtask

  // grant responder: grant while requested, hold until request drops
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && allow_gnt && !bus_gnt) begin
        if (dly_cnt == 0) bus_gnt = 1'b1;
        else dly_cnt--;
      end else if (!bus_req && bus_gnt) begin
        bus_gnt = 1'b0;
        dly_cnt = random_gnt ? int'($urandom % 4) : 0;
      end
    end
  end

  // strobe monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1'b1; prev_req = 1'b0; cas_low_run = 0;
    end else begin
      cyc_no++;
      if (prev_ras && !ras_n) begin
        falls_total++;
        if (!init_done) wake_falls++;
        tenure_falls++;
        check("R2 grant at RAS fall", bus_gnt === 1'b1, bus_gnt, 1);
        check("R4 WE high at RAS fall", we_n === 1'b1, we_n, 1);
        cur_ro = cas_n;
        if (!cas_n) check("R3 CAS lead", cas_low_run >= TS, cas_low_run, TS);
        else begin
          ro_falls++;
          check("R5 row value", row_addr == exp_row, row_addr, exp_row);
          if (exp_row == 10'd0 && ro_falls > 1) wrap_seen = 1'b1;
        end
        if (tenure_falls > 1)
          check("R2 back-to-back spacing", cyc_no - last_fall == CYC_LEN, cyc_no - last_fall, CYC_LEN);
        spacing = cyc_no - last_fall;
        last_fall = cyc_no;
        fall_row = row_addr;
        kind_bad = 1'b0;
      end else if (!prev_ras && !ras_n) begin
        if (cas_n !== cur_ro || row_addr !== fall_row) kind_bad = 1'b1;
      end else if (!prev_ras && ras_n) begin
        check("R10 cycle kind held", !kind_bad, kind_bad, 0);
        if (cur_ro) exp_row = next_row(exp_row);
      end
      cas_low_run = cas_n ? 0 : cas_low_run + 1;
      if (prev_req && !bus_req) begin
        last_tenure = tenure_falls;
        tenure_falls = 0;
      end
      prev_ras = ras_n;
      prev_req = bus_req;
    end
  end

  task automatic run_all();
    int req_seen = 0;
    int seed_dummy = int'($urandom(32'h5eed));
    // R1 reset state
    repeat (3) step();
    check("R1 ras_n", ras_n === 1'b1, ras_n, 1);
    check("R1 cas_n", cas_n === 1'b1, cas_n, 1);
    check("R1 we_n", we_n === 1'b1, we_n, 1);
    check("R1 bus_req", bus_req === 1'b0, bus_req, 0);
    check("R1 seq_active", seq_active === 1'b0, seq_active, 0);
    check("R1 init_done", init_done === 1'b0, init_done, 0);
    check("R1 row_addr", row_addr === 10'd0, row_addr, 0 + seed_dummy * 0);
    rst_n = 1'b1;
    // R6 pause
    for (int k = 0; k < PAUSE; k++) begin
      step();
      if (bus_req) req_seen++;
    end
    check("R6 no request during pause", req_seen == 0, req_seen, 0);
    // R7 wake-up
    while (!init_done) step();
    check("R7 wake-up cycle count", wake_falls == 8, wake_falls, 8);
    check("R5 row unchanged by CAS-first", row_addr == 10'd0, row_addr, 0);
    // R8 interval
    repeat (3) wait_fall();
    check("R8 interval spacing", spacing == INTERVAL, spacing, INTERVAL);
    wait_fall();
    check("R8 interval spacing", spacing == INTERVAL, spacing, INTERVAL);
    check("R7 init_done held", init_done === 1'b1, init_done, 1);
    // R9 backlog saturation
    wait_fall();
    allow_gnt = 1'b0;
    repeat (15 * INTERVAL + 60) step();
    check("R9 request held while denied", bus_req === 1'b1, bus_req, 1);
    allow_gnt = 1'b1;
    while (!bus_req || !bus_gnt) step();
    while (bus_req) step();
    step();
    check("R9 backlog issued in one grant", last_tenure == 8, last_tenure, 8);
    // R10 directed mode flip inside a CAS-first cycle
    mode_ras_only = 1'b0;
    wait_fall();
    mode_ras_only = 1'b1;
    while (!ras_n) step();
    check("R10 flipped cycle stays CAS-first", cur_ro == 1'b0, cur_ro, 0);
    check("R5 row unchanged after CAS-first", row_addr == exp_row, row_addr, exp_row);
    // random phase
    random_gnt = 1'b1;
    for (int i = 0; i < 40; i++) begin
      repeat (1 + ($urandom % 300)) step();
      mode_ras_only = $urandom % 2;
    end
    // row wrap
    mode_ras_only = 1'b1;
    while (ro_falls < 1030) step();
    check("R5 row counter wrapped", wrap_seen, wrap_seen, 1);
    check("R5 row tracks count", row_addr == exp_row, row_addr, exp_row);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1..: actual %0d cycles expected fewer", WATCHDOG);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule